// File: doc/BRIEF.md
# Parallel camera pixel capture

This block sits in the pixel-clock domain of an image sensor that delivers video as a byte-wide parallel stream, with a vertical sync line and a line-valid qualifier. Each pixel arrives as two bytes on two consecutive pixel-clock edges. The block joins each pair into one 16-bit RGB565 word. It emits the word with a one-cycle valid strobe and the pixel's column and row, ready to be written into a frame buffer.

Capture is armed per frame. The block waits for the vertical sync to go high and then return low, and only then accepts bytes. It reports the start of each frame and the end of each line with single-cycle pulses. The sensor gates its pixel clock during horizontal blank, so bytes arrive only inside active lines. Lines longer than the configured width, and rows past the configured height, are kept out of the frame buffer. An overrun flag records the excess width.

Top module: `cam_pixel_capture`

## Requirements
- R1: After reset no byte is captured until `vsync` has been sampled high and later sampled low; `frame_start` is a one-cycle pulse in the cycle after the edge where `vsync` is first sampled low after being high.
- R2: The first byte of a pair forms `pix_data[15:8]` (red in bits 15:11, upper green in 10:8) and the second forms `pix_data[7:0]` (lower green in 7:5, blue in 4:0); `pix_valid` is high for exactly the cycle after the edge that samples the second byte.
- R3: A byte is sampled only on a rising `pclk` edge where `href` is high; edges with `href` low contribute nothing.
- R4: At each rising edge of `href` the pairing restarts, so the first byte of every line is a high byte even if the previous line held an odd number of bytes.
- R5: `pix_x` is 0 for the first pixel of a line and rises by one per pixel; `pix_y` is 0 on the first line of a frame and rises by one after each falling edge of `href`; both restart at each frame start.
- R6: `line_end` is a one-cycle pulse in the cycle after an edge that sees `href` low following `href` high inside an armed frame.
- R7: A pixel that completes when `LINE_PIX` pixels were already seen on the line is not emitted and sets `overrun`, which stays high until the next frame start clears it.
- R8: Pixels on rows at or beyond `FRAME_LINES` are not emitted, so `pix_y` never reaches `FRAME_LINES` while `pix_valid` is high.
- R9: If `vsync` goes high inside a frame, capture stops at once; when it returns low, a new frame starts with a fresh `frame_start` and counters at 0.
- R10: While and right after synchronous reset, all outputs are 0.

Top module parameters: `LINE_PIX` (320), `FRAME_LINES` (240), with `XW` and `YW` derived as the bits needed to hold those counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Sensor pixel clock, capture clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync | input | 1 | Vertical sync from the sensor |
| href | input | 1 | Line-valid qualifier for the byte bus |
| din | input | 8 | Parallel byte bus |
| pix_valid | output | 1 | One-cycle strobe for a completed pixel |
| pix_data | output | 16 | RGB565 pixel word |
| pix_x | output | XW (9) | Column of the emitted pixel |
| pix_y | output | YW (8) | Row of the emitted pixel |
| frame_start | output | 1 | One-cycle pulse when a frame is armed |
| line_end | output | 1 | One-cycle pulse when a line closes |
| overrun | output | 1 | A line exceeded `LINE_PIX` pixels this frame |

## Verification
Bytes are first driven with no frame armed and with `vsync` held high, which separates a capture path that waits for the high-then-low sequence from one that triggers on a level. Regular even-length lines with a distinct value per pixel show whether byte order, column and row are right. Lines with an odd byte count, and bytes driven while `href` is low, show whether pairing restarts per line and whether unqualified bytes are excluded. An over-long line, a frame taller than the limit, and a `vsync` pulse inside a frame test the overrun flag and its clearing, the row limit, and re-arming.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

    localparam int BYTE_W = 8;
    localparam int PIX_W  = 2 * BYTE_W;

    typedef enum logic [1:0] {
        VS_SEEK_HIGH = 2'd0,
        VS_SEEK_LOW  = 2'd1,
        VS_ACTIVE    = 2'd2
    } vs_state_e;

    typedef enum logic {
        PH_HI = 1'b0,
        PH_LO = 1'b1
    } phase_e;

    typedef struct packed {
        logic [4:0] red;
        logic [5:0] green;
        logic [4:0] blue;
    } rgb565_t;

    function automatic rgb565_t join_bytes(input logic [BYTE_W-1:0] hi,
                                           input logic [BYTE_W-1:0] lo);
        return rgb565_t'({hi, lo});
    endfunction

endpackage

// File: rtl/cam_frame_sync.sv
module cam_frame_sync
    import cam_cap_pkg::*;
(
    input  logic pclk,
    input  logic rst,
    input  logic vsync,
    output logic start_now,
    output logic active,
    output logic frame_start
);

    vs_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        case (state)
            VS_SEEK_HIGH: if (vsync)  state_nxt = VS_SEEK_LOW;
            VS_SEEK_LOW:  if (!vsync) state_nxt = VS_ACTIVE;
            VS_ACTIVE:    if (vsync)  state_nxt = VS_SEEK_LOW;
            default:                  state_nxt = VS_SEEK_HIGH;
        endcase
    end

    assign start_now = (state == VS_SEEK_LOW) && !vsync;
    assign active    = (state == VS_ACTIVE) && !vsync;

    always_ff @(posedge pclk) begin
        if (rst) begin
            state       <= VS_SEEK_HIGH;
            frame_start <= 1'b0;
        end else begin
            state       <= state_nxt;
            frame_start <= start_now;
        end
    end

endmodule

// File: rtl/cam_byte_pairer.sv
module cam_byte_pairer
    import cam_cap_pkg::*;
(
    input  logic              pclk,
    input  logic              rst,
    input  logic              take,
    input  logic              line_rise,
    input  logic [BYTE_W-1:0] din,
    output logic              pair_done,
    output rgb565_t           word
);

    phase_e            phase;
    phase_e            phase_eff;
    logic [BYTE_W-1:0] hi_byte;

    assign phase_eff = line_rise ? PH_HI : phase;
    assign pair_done = take && (phase_eff == PH_LO);
    assign word      = join_bytes(hi_byte, din);

    always_ff @(posedge pclk) begin
        if (rst) begin
            phase   <= PH_HI;
            hi_byte <= '0;
        end else if (take) begin
            if (phase_eff == PH_HI) begin
                hi_byte <= din;
                phase   <= PH_LO;
            end else begin
                phase   <= PH_HI;
            end
        end
    end

endmodule

// File: rtl/cam_pos_counter.sv
module cam_pos_counter
    import cam_cap_pkg::*;
#(
    parameter int LINE_PIX    = 320,
    parameter int FRAME_LINES = 240,
    parameter int XW          = $clog2(LINE_PIX + 1),
    parameter int YW          = $clog2(FRAME_LINES + 1)
) (
    input  logic          pclk,
    input  logic          rst,
    input  logic          clear,
    input  logic          pair_done,
    input  rgb565_t       word,
    input  logic          line_fall,
    output logic          pix_valid,
    output logic [PIX_W-1:0] pix_data,
    output logic [XW-1:0] pix_x,
    output logic [YW-1:0] pix_y,
    output logic          line_end,
    output logic          overrun
);

    localparam logic [XW-1:0] X_LIM = XW'(LINE_PIX);
    localparam logic [YW-1:0] Y_LIM = YW'(FRAME_LINES);

    logic [XW-1:0] x_cnt;
    logic [YW-1:0] y_cnt;

    always_ff @(posedge pclk) begin
        if (rst) begin
            x_cnt     <= '0;
            y_cnt     <= '0;
            pix_valid <= 1'b0;
            pix_data  <= '0;
            pix_x     <= '0;
            pix_y     <= '0;
            line_end  <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            pix_valid <= 1'b0;
            line_end  <= 1'b0;
            if (clear) begin
                x_cnt   <= '0;
                y_cnt   <= '0;
                overrun <= 1'b0;
            end else begin
                if (pair_done) begin
                    if (x_cnt == X_LIM) begin
                        overrun <= 1'b1;
                    end else begin
                        x_cnt <= x_cnt + 1'b1;
                        if (y_cnt < Y_LIM) begin
                            pix_valid <= 1'b1;
                            pix_data  <= word;
                            pix_x     <= x_cnt;
                            pix_y     <= y_cnt;
                        end
                    end
                end
                if (line_fall) begin
                    x_cnt    <= '0;
                    line_end <= 1'b1;
                    if (y_cnt != Y_LIM) y_cnt <= y_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cam_pixel_capture.sv
module cam_pixel_capture
    import cam_cap_pkg::*;
#(
    parameter int LINE_PIX    = 320,
    parameter int FRAME_LINES = 240,
    parameter int XW          = $clog2(LINE_PIX + 1),
    parameter int YW          = $clog2(FRAME_LINES + 1)
) (
    input  logic              pclk,
    input  logic              rst,
    input  logic              vsync,
    input  logic              href,
    input  logic [BYTE_W-1:0] din,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix_data,
    output logic [XW-1:0]     pix_x,
    output logic [YW-1:0]     pix_y,
    output logic              frame_start,
    output logic              line_end,
    output logic              overrun
);

    logic    href_d;
    logic    start_now;
    logic    active;
    logic    take;
    logic    line_rise;
    logic    line_fall;
    logic    pair_done;
    rgb565_t word;

    always_ff @(posedge pclk) begin
        if (rst) href_d <= 1'b0;
        else     href_d <= href;
    end

    assign line_rise = href && !href_d;
    assign line_fall = href_d && !href && active;
    assign take      = href && active;

    cam_frame_sync u_sync (
        .pclk        (pclk),
        .rst         (rst),
        .vsync       (vsync),
        .start_now   (start_now),
        .active      (active),
        .frame_start (frame_start)
    );

    cam_byte_pairer u_pair (
        .pclk      (pclk),
        .rst       (rst),
        .take      (take),
        .line_rise (line_rise),
        .din       (din),
        .pair_done (pair_done),
        .word      (word)
    );

    cam_pos_counter #(
        .LINE_PIX    (LINE_PIX),
        .FRAME_LINES (FRAME_LINES),
        .XW          (XW),
        .YW          (YW)
    ) u_pos (
        .pclk      (pclk),
        .rst       (rst),
        .clear     (start_now),
        .pair_done (pair_done),
        .word      (word),
        .line_fall (line_fall),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .line_end  (line_end),
        .overrun   (overrun)
    );

endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk #(
    parameter int LINE_PIX    = 320,
    parameter int FRAME_LINES = 240,
    parameter int XW          = $clog2(LINE_PIX + 1),
    parameter int YW          = $clog2(FRAME_LINES + 1)
) (
    input logic          pclk,
    input logic          rst,
    input logic          vsync,
    input logic          pix_valid,
    input logic [XW-1:0] pix_x,
    input logic [YW-1:0] pix_y,
    input logic          frame_start,
    input logic          line_end,
    input logic          overrun
);

    AST_FRAME_PULSE: assert property (@(posedge pclk) disable iff (rst)
        frame_start |=> !frame_start);                        // R1

    AST_PAIR_GAP: assert property (@(posedge pclk) disable iff (rst)
        pix_valid |=> !pix_valid);                            // R2

    AST_LINE_PULSE: assert property (@(posedge pclk) disable iff (rst)
        line_end |=> !line_end);                              // R6

    AST_X_RANGE: assert property (@(posedge pclk) disable iff (rst)
        pix_valid |-> (pix_x < XW'(LINE_PIX)));               // R7

    AST_OVR_CLEAR: assert property (@(posedge pclk) disable iff (rst)
        $fell(overrun) |-> frame_start);                      // R7

    AST_Y_RANGE: assert property (@(posedge pclk) disable iff (rst)
        pix_valid |-> (pix_y < YW'(FRAME_LINES)));            // R8

    AST_NO_PIX_IN_VSYNC: assert property (@(posedge pclk) disable iff (rst)
        pix_valid |-> !$past(vsync));                         // R9

endmodule

bind cam_pixel_capture cam_capture_chk #(
    .LINE_PIX    (LINE_PIX),
    .FRAME_LINES (FRAME_LINES),
    .XW          (XW),
    .YW          (YW)
) u_chk (
    .pclk        (pclk),
    .rst         (rst),
    .vsync       (vsync),
    .pix_valid   (pix_valid),
    .pix_x       (pix_x),
    .pix_y       (pix_y),
    .frame_start (frame_start),
    .line_end    (line_end),
    .overrun     (overrun)
);

// File: tb/sim_cam_pixel_capture.sv
module sim_cam_pixel_capture;

    localparam int CLK_PERIOD = 10;
    localparam int LINE_PIX    = 320;
    localparam int FRAME_LINES = 240;
    localparam int XW = $clog2(LINE_PIX + 1);
    localparam int YW = $clog2(FRAME_LINES + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          vsync = 1'b0;
    logic          href = 1'b0;
    logic [7:0]    din = 8'h00;
    logic          pix_valid;
    logic [15:0]   pix_data;
    logic [XW-1:0] pix_x;
    logic [YW-1:0] pix_y;
    logic          frame_start;
    logic          line_end;
    logic          overrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0]   got_d[$];
    logic [XW-1:0] got_x[$];
    logic [YW-1:0] got_y[$];
    int n_fs = 0;
    int n_le = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cam_pixel_capture #(.LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES)) u0 (
        .pclk(clk), .rst(rst), .vsync(vsync), .href(href), .din(din),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_x(pix_x), .pix_y(pix_y),
        .frame_start(frame_start), .line_end(line_end), .overrun(overrun)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (pix_valid) begin
                got_d.push_back(pix_data);
                got_x.push_back(pix_x);
                got_y.push_back(pix_y);
            end
            if (frame_start) n_fs++;
            if (line_end)    n_le++;
        end
    end

    function automatic logic [15:0] pixval(input int seed, input int k);
        return 16'((seed * 16'h0123) ^ (k * 16'h0101) ^ 16'h5A3C);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        got_d.delete(); got_x.delete(); got_y.delete();
        n_fs = 0; n_le = 0;
    endtask

    task automatic send_bytes(input int nbytes, input int seed);
        for (int j = 0; j < nbytes; j++) begin
            logic [15:0] v;
            v = pixval(seed, j / 2);
            @(negedge clk);
            href = 1'b1;
            din  = (j % 2 == 0) ? v[15:8] : v[7:0];
        end
        @(negedge clk);
        href = 1'b0;
        din  = 8'h00;
        repeat (3) @(negedge clk);
    endtask

    task automatic start_frame();
        @(negedge clk); vsync = 1'b1;
        repeat (3) @(negedge clk);
        vsync = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_line(input int base, input int npix, input int seed,
                              input int row, input string req);
        for (int k = 0; k < npix; k++) begin
            chk(got_d[base + k] == pixval(seed, k), req, "pixel data",
                int'(got_d[base + k]), int'(pixval(seed, k)));
            chk(got_x[base + k] == XW'(k), req, "pix_x", int'(got_x[base + k]), k);
            chk(got_y[base + k] == YW'(row), req, "pix_y", int'(got_y[base + k]), row);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(pix_valid == 1'b0 && frame_start == 1'b0 && line_end == 1'b0,
            "R10", "strobes after reset", int'({pix_valid, frame_start, line_end}), 0);
        chk(overrun == 1'b0 && pix_x == '0 && pix_y == '0 && pix_data == '0,
            "R10", "values after reset", int'(pix_data), 0);
    endtask

    task automatic t_unarmed();
        clear_mon();
        send_bytes(8, 1);
        chk(got_d.size() == 0, "R1", "pixels before vsync", got_d.size(), 0);
        @(negedge clk); vsync = 1'b1;
        send_bytes(8, 1);
        chk(got_d.size() == 0, "R1", "pixels with vsync high only", got_d.size(), 0);
        chk(n_fs == 0, "R1", "frame_start while vsync high", n_fs, 0);
        chk(n_le == 0, "R6", "line_end outside frame", n_le, 0);
        vsync = 1'b0;
        repeat (3) @(negedge clk);
        chk(n_fs == 1, "R1", "frame_start after high-low", n_fs, 1);
    endtask

    task automatic t_basic();
        clear_mon();
        start_frame();
        chk(n_fs == 1, "R1", "frame_start count", n_fs, 1);
        send_bytes(8, 2);
        chk(n_le == 1, "R6", "line_end after first line", n_le, 1);
        send_bytes(8, 3);
        chk(got_d.size() == 8, "R2", "pixel count for two lines", got_d.size(), 8);
        if (got_d.size() == 8) begin
            check_line(0, 4, 2, 0, "R2 R5");
            check_line(4, 4, 3, 1, "R2 R5");
        end
        chk(n_le == 2, "R6", "line_end count", n_le, 2);
    endtask

    task automatic t_href_low();
        clear_mon();
        repeat (6) begin
            @(negedge clk); din = 8'hA5;
        end
        @(negedge clk); din = 8'h00;
        chk(got_d.size() == 0, "R3", "pixels with href low", got_d.size(), 0);
        send_bytes(4, 4);
        chk(got_d.size() == 2, "R3", "pixels after idle bytes", got_d.size(), 2);
        if (got_d.size() == 2) check_line(0, 2, 4, 2, "R3");
    endtask

    task automatic t_lost_byte();
        clear_mon();
        start_frame();
        send_bytes(7, 5);
        chk(got_d.size() == 3, "R4", "pixels from odd line", got_d.size(), 3);
        send_bytes(8, 6);
        chk(got_d.size() == 7, "R4", "pixels after odd line", got_d.size(), 7);
        if (got_d.size() == 7) begin
            check_line(0, 3, 5, 0, "R4");
            check_line(3, 4, 6, 1, "R4");
        end
    endtask

    task automatic t_overrun();
        clear_mon();
        start_frame();
        chk(overrun == 1'b0, "R7", "overrun at frame start", overrun, 0);
        send_bytes(2 * LINE_PIX, 7);
        chk(overrun == 1'b0, "R7", "overrun at exact width", overrun, 0);
        send_bytes(2 * (LINE_PIX + 2), 8);
        chk(got_d.size() == 2 * LINE_PIX, "R7", "pixels emitted", got_d.size(), 2 * LINE_PIX);
        if (got_d.size() == 2 * LINE_PIX) begin
            chk(got_x[2 * LINE_PIX - 1] == XW'(LINE_PIX - 1), "R7", "last x",
                int'(got_x[2 * LINE_PIX - 1]), LINE_PIX - 1);
            chk(got_d[2 * LINE_PIX - 1] == pixval(8, LINE_PIX - 1), "R7", "last data",
                int'(got_d[2 * LINE_PIX - 1]), int'(pixval(8, LINE_PIX - 1)));
        end
        chk(overrun == 1'b1, "R7", "overrun after long line", overrun, 1);
        send_bytes(4, 9);
        chk(overrun == 1'b1, "R7", "overrun held", overrun, 1);
        clear_mon();
        start_frame();
        chk(overrun == 1'b0, "R7", "overrun cleared by frame start", overrun, 0);
        send_bytes(2, 10);
        chk(got_d.size() == 1, "R5", "pixel count new frame", got_d.size(), 1);
        if (got_d.size() == 1) check_line(0, 1, 10, 0, "R5");
    endtask

    task automatic t_vsync_mid();
        clear_mon();
        start_frame();
        send_bytes(4, 11);
        @(negedge clk); vsync = 1'b1;
        send_bytes(8, 12);
        chk(got_d.size() == 2, "R9", "pixels during vsync high", got_d.size(), 2);
        vsync = 1'b0;
        repeat (3) @(negedge clk);
        chk(n_fs == 2, "R9", "frame_start after rearm", n_fs, 2);
        send_bytes(4, 13);
        chk(got_d.size() == 4, "R9", "pixels after rearm", got_d.size(), 4);
        if (got_d.size() == 4) check_line(2, 2, 13, 0, "R9");
    endtask

    task automatic t_frame_lines();
        clear_mon();
        start_frame();
        for (int l = 0; l < FRAME_LINES + 1; l++) send_bytes(2, l);
        chk(got_d.size() == FRAME_LINES, "R8", "pixels in tall frame", got_d.size(), FRAME_LINES);
        chk(n_le == FRAME_LINES + 1, "R6", "line_end per line", n_le, FRAME_LINES + 1);
        if (got_d.size() == FRAME_LINES) begin
            chk(got_y[FRAME_LINES - 1] == YW'(FRAME_LINES - 1), "R8", "last row",
                int'(got_y[FRAME_LINES - 1]), FRAME_LINES - 1);
            chk(got_d[FRAME_LINES - 1] == pixval(FRAME_LINES - 1, 0), "R8", "last row data",
                int'(got_d[FRAME_LINES - 1]), int'(pixval(FRAME_LINES - 1, 0)));
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_unarmed();
        t_basic();
        t_href_low();
        t_lost_byte();
        t_overrun();
        t_vsync_mid();
        t_frame_lines();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule